// File: doc/BRIEF.md
# Calibrated RTC Seconds Counter

This block is a real-time-clock core that runs from a slow oscillator enable strobe (`osc_tick`, one pulse per crystal period, sampled on the fast system clock). It divides the strobe down to seconds using a programmable tick count and an optional 4-bit fractional trim. The trim lengthens some seconds by one tick so that the average second matches a crystal whose frequency is not an integer number of ticks. A 32-bit seconds counter advances at each second boundary. The block raises a per-second event and an alarm event, each gated by its own enable.

Software reaches the core over a single-cycle register port. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. A new time is written to the set-time register and becomes live at the next second boundary. Writing the calibration register restarts the tick divider, so the following boundary falls exactly one calibrated period after the write.

The divider is a two-state machine:
- `TK_COUNT` counts strobes. On the last tick of a normal second it stays in `TK_COUNT` and signals a boundary. On the last tick of a second that owes a trim tick it moves to `TK_EXTRA`.
- `TK_EXTRA` consumes the extra tick, signals the boundary and returns to `TK_COUNT`.
- A calibration write forces `TK_COUNT` from either state.

Top module: `sec_rtc`

## Requirements
- R1: After reset the following values hold:
  - calibration readback (0x0C) is 0x198233: tick count 0x8233 in bits 15:0, trim 9 in bits 19:16, trim enable in bit 20;
  - current seconds (0x10), interrupt status (0x20) and interrupt mask (0x24) read 0;
  - both interrupt outputs are low.
- R2: A write to 0x08 stores bits 20:0 of the data, which read back at 0x0C with upper bits zero. The write clears the tick counter and the trim position, so the next boundary falls a full calibrated period after the write edge.
- R3: With trim disabled and tick count T, every second lasts exactly T strobes. At each boundary the seconds value at 0x10 increments by one and status bit 0 sets.
- R4: With trim enabled (bit 20) and trim value N (bits 19:16), the seconds at positions 0..N-1 of each 16-second cycle last T+1 strobes and the others last T. Position 0 is the first second after a calibration write.
- R5: A write to 0x00 is readable at 0x04 at once but loads into the seconds counter only at the next boundary; until then 0x10 returns the old count. A set-time write on the same edge as a boundary is loaded at the following boundary, and that boundary increments normally.
- R6: The seconds counter wraps from 0xFFFFFFFF to 0.
- R7: 0x14 returns the live tick counter in bits 15:0 and zero above.
- R8: Status bit 0 is the second event and bit 1 is the alarm event. Writing 1 to 0x20 clears a bit and writing 0 leaves it. An event arriving on the same edge as a clear leaves the bit set. Bits set whether or not they are enabled.
- R9: Writing 1 to a bit of 0x28 enables that interrupt, and writing 1 to 0x2C disables it. 0x24 reads the enabled set. `irq_sec` and `irq_alarm` are each high exactly while their status bit and enable are both set.
- R10: The alarm value is written and read at 0x18. Alarm status sets at a boundary whose new seconds value equals the alarm value.
- R11: While `osc_tick` is low, the tick counter and seconds hold.

Ports table (widths at the default parameters):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_sec | output | 1 | Per-second interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
Two functions can land on the same edge: a software write and a second boundary. The bench counts strobes from a calibration write so that it knows each boundary edge exactly. It then issues a status-clear write on one boundary edge and expects bit 0 to stay set. It issues a set-time write on another boundary edge and expects an ordinary increment there, with the new value appearing one second later. Randomised calibration words with trim on and off are judged by measuring every second's length against a bench function of T, N and position.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    typedef enum logic [0:0] {
        TK_COUNT = 1'b0,
        TK_EXTRA = 1'b1
    } tick_state_e;

    localparam logic [7:0] OFS_SET_WR = 8'h00;
    localparam logic [7:0] OFS_SET_RD = 8'h04;
    localparam logic [7:0] OFS_CAL_WR = 8'h08;
    localparam logic [7:0] OFS_CAL_RD = 8'h0C;
    localparam logic [7:0] OFS_CUR    = 8'h10;
    localparam logic [7:0] OFS_TICK   = 8'h14;
    localparam logic [7:0] OFS_ALARM  = 8'h18;
    localparam logic [7:0] OFS_STS    = 8'h20;
    localparam logic [7:0] OFS_MASK   = 8'h24;
    localparam logic [7:0] OFS_EN     = 8'h28;
    localparam logic [7:0] OFS_DIS    = 8'h2C;

    localparam int EVT_SEC   = 0;
    localparam int EVT_ALARM = 1;
    localparam int EVT_N     = 2;

endpackage

// File: rtl/sec_rtc_ticker.sv
module sec_rtc_ticker
    import sec_rtc_pkg::*;
#(
    parameter int TICK_W = 16,
    parameter int TRIM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              restart,
    input  logic [TICK_W-1:0] tick_max,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              trim_on,
    output logic [TICK_W-1:0] tick_cnt,
    output logic              sec_pulse
);

    localparam logic [TICK_W-1:0] T_ONE = TICK_W'(1);
    localparam logic [TRIM_W-1:0] P_ONE = TRIM_W'(1);

    tick_state_e       state, state_nxt;
    logic [TICK_W-1:0] cnt_nxt;
    logic [TRIM_W-1:0] phase, phase_nxt;
    logic              last_tick;
    logic              extra_due;

    assign last_tick = (tick_cnt == tick_max - T_ONE);
    assign extra_due = trim_on && (phase < trim_val);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TK_COUNT;
        else        state <= state_nxt;
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            phase    <= '0;
        end else begin
            tick_cnt <= cnt_nxt;
            phase    <= phase_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        cnt_nxt   = tick_cnt;
        phase_nxt = phase;
        sec_pulse = 1'b0;
        if (restart) begin
            state_nxt = TK_COUNT;
            cnt_nxt   = '0;
            phase_nxt = '0;
        end else if (osc_tick) begin
            unique case (state)
                TK_COUNT: begin
                    if (!last_tick) begin
                        cnt_nxt = tick_cnt + T_ONE;
                    end else if (extra_due) begin
                        state_nxt = TK_EXTRA;
                        cnt_nxt   = tick_cnt + T_ONE;
                    end else begin
                        sec_pulse = 1'b1;
                        cnt_nxt   = '0;
                        phase_nxt = phase + P_ONE;
                    end
                end
                TK_EXTRA: begin
                    state_nxt = TK_COUNT;
                    sec_pulse = 1'b1;
                    cnt_nxt   = '0;
                    phase_nxt = phase + P_ONE;
                end
                default: state_nxt = TK_COUNT;
            endcase
        end
    end

endmodule

// File: rtl/sec_rtc_clock.sv
module sec_rtc_clock #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_pulse,
    input  logic             set_wr,
    input  logic             alarm_wr,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] cur_sec,
    output logic [SEC_W-1:0] set_hold,
    output logic             set_pending,
    output logic [SEC_W-1:0] alarm_val,
    output logic             alarm_hit
);

    logic [SEC_W-1:0] sec_nxt;

    assign sec_nxt   = set_pending ? set_hold : cur_sec + SEC_W'(1);
    assign alarm_hit = sec_pulse && (sec_nxt == alarm_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sec     <= '0;
            set_hold    <= '0;
            set_pending <= 1'b0;
            alarm_val   <= '0;
        end else begin
            if (set_wr)   set_hold  <= wdata;
            if (alarm_wr) alarm_val <= wdata;
            if (sec_pulse) begin
                cur_sec     <= sec_nxt;
                set_pending <= set_wr;
            end else if (set_wr) begin
                set_pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sec_rtc_irq.sv
module sec_rtc_irq #(
    parameter int EVT_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             clr_wr,
    input  logic             en_wr,
    input  logic             dis_wr,
    input  logic [EVT_N-1:0] wbits,
    output logic [EVT_N-1:0] status,
    output logic [EVT_N-1:0] enabled,
    output logic [EVT_N-1:0] irq
);

    logic [EVT_N-1:0] clr_bits, en_bits, dis_bits;

    assign clr_bits = clr_wr ? wbits : '0;
    assign en_bits  = en_wr  ? wbits : '0;
    assign dis_bits = dis_wr ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status  <= '0;
            enabled <= '0;
        end else begin
            status  <= (status & ~clr_bits) | evt;
            enabled <= (enabled | en_bits) & ~dis_bits;
        end
    end

    for (genvar g = 0; g < EVT_N; g++) begin : g_irq
        assign irq[g] = status[g] & enabled[g];
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int          TICK_W    = 16,
    parameter int          TRIM_W    = 4,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 6,
    parameter logic [31:0] CAL_RESET = 32'h0019_8233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_sec,
    output logic              irq_alarm
);

    localparam int SEC_W  = DATA_W;
    localparam int CAL_W  = TICK_W + TRIM_W + 1;
    localparam int TRIM_L = TICK_W;
    localparam int TRIM_H = TICK_W + TRIM_W - 1;

    logic [CAL_W-1:0]  cal_reg;
    logic              cal_wr, set_wr, alarm_wr, clr_wr, en_wr, dis_wr;
    logic [TICK_W-1:0] tick_cnt;
    logic              sec_pulse;
    logic [SEC_W-1:0]  cur_sec, set_hold, alarm_val;
    logic              set_pending, alarm_hit;
    logic [EVT_N-1:0]  int_status, int_en, irq_vec, evt;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ofs[ADDR_W-1:0];
    endfunction

    assign cal_wr   = bus_wr && hit(bus_addr, OFS_CAL_WR);
    assign set_wr   = bus_wr && hit(bus_addr, OFS_SET_WR);
    assign alarm_wr = bus_wr && hit(bus_addr, OFS_ALARM);
    assign clr_wr   = bus_wr && hit(bus_addr, OFS_STS);
    assign en_wr    = bus_wr && hit(bus_addr, OFS_EN);
    assign dis_wr   = bus_wr && hit(bus_addr, OFS_DIS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cal_reg <= CAL_RESET[CAL_W-1:0];
        else if (cal_wr) cal_reg <= bus_wdata[CAL_W-1:0];
    end

    sec_rtc_ticker #(.TICK_W(TICK_W), .TRIM_W(TRIM_W)) u_ticker (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .restart  (cal_wr),
        .tick_max (cal_reg[TICK_W-1:0]),
        .trim_val (cal_reg[TRIM_H:TRIM_L]),
        .trim_on  (cal_reg[CAL_W-1]),
        .tick_cnt (tick_cnt),
        .sec_pulse(sec_pulse)
    );

    sec_rtc_clock #(.SEC_W(SEC_W)) u_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_pulse  (sec_pulse),
        .set_wr     (set_wr),
        .alarm_wr   (alarm_wr),
        .wdata      (bus_wdata),
        .cur_sec    (cur_sec),
        .set_hold   (set_hold),
        .set_pending(set_pending),
        .alarm_val  (alarm_val),
        .alarm_hit  (alarm_hit)
    );

    always_comb begin
        evt            = '0;
        evt[EVT_SEC]   = sec_pulse;
        evt[EVT_ALARM] = alarm_hit;
    end

    sec_rtc_irq #(.EVT_N(EVT_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr_wr (clr_wr),
        .en_wr  (en_wr),
        .dis_wr (dis_wr),
        .wbits  (bus_wdata[EVT_N-1:0]),
        .status (int_status),
        .enabled(int_en),
        .irq    (irq_vec)
    );

    assign irq_sec   = irq_vec[EVT_SEC];
    assign irq_alarm = irq_vec[EVT_ALARM];

    always_comb begin
        bus_rdata = '0;
        if      (hit(bus_addr, OFS_SET_RD)) bus_rdata = set_hold;
        else if (hit(bus_addr, OFS_CAL_RD)) bus_rdata[CAL_W-1:0] = cal_reg;
        else if (hit(bus_addr, OFS_CUR))    bus_rdata = cur_sec;
        else if (hit(bus_addr, OFS_TICK))   bus_rdata[TICK_W-1:0] = tick_cnt;
        else if (hit(bus_addr, OFS_ALARM))  bus_rdata = alarm_val;
        else if (hit(bus_addr, OFS_STS))    bus_rdata[EVT_N-1:0] = int_status;
        else if (hit(bus_addr, OFS_MASK))   bus_rdata[EVT_N-1:0] = int_en;
    end

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
    parameter int TICK_W = 16,
    parameter int SEC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_tick,
    input logic              cal_wr,
    input logic              sec_pulse,
    input logic              set_pending,
    input logic              alarm_hit,
    input logic [TICK_W-1:0] tick_cnt,
    input logic [SEC_W-1:0]  cur_sec,
    input logic [SEC_W-1:0]  set_hold,
    input logic [1:0]        int_status
);

    assert_cal_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr |=> tick_cnt == '0);

    assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !set_pending) |=> cur_sec == $past(cur_sec) + SEC_W'(1));

    assert_set_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && set_pending) |=> cur_sec == $past(set_hold));

    assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_pulse |=> $stable(cur_sec));

    assert_sec_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> int_status[0]);

    assert_alarm_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> int_status[1]);

    assert_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !cal_wr) |=> $stable(tick_cnt));

endmodule

bind sec_rtc sec_rtc_chk #(.TICK_W(TICK_W), .SEC_W(SEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .cal_wr     (cal_wr),
    .sec_pulse  (sec_pulse),
    .set_pending(set_pending),
    .alarm_hit  (alarm_hit),
    .tick_cnt   (tick_cnt),
    .cur_sec    (cur_sec),
    .set_hold   (set_hold),
    .int_status (int_status)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_sec, irq_alarm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sec_rtc u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one posedge consumed; returns at the following negedge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int unsigned exp_period(input int unsigned t, input int unsigned n,
                                               input bit en, input int unsigned pos);
        return t + ((en && ((pos % 16) < n)) ? 1 : 0);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, t0, prev;
        int unsigned seed;
        seed = $urandom(32'd4711);
        step(5);
        rst_n = 1'b1;
        step(1);

        rd(6'h0C, v); chk("R1 cal reset", v, 32'h0019_8233);
        rd(6'h10, v); chk("R1 seconds reset", v, 0);
        rd(6'h20, v); chk("R1 status reset", v, 0);
        rd(6'h24, v); chk("R1 mask reset", v, 0);
        chk("R1 irq reset", {30'd0, irq_alarm, irq_sec}, 0);

        osc_tick = 1'b0;
        rd(6'h14, t0);
        step(3);
        rd(6'h14, v); chk("R11 tick holds", v, t0);
        osc_tick = 1'b1;

        // T=4, trim off; junk in upper bits
        wr(6'h08, 32'hFFE0_0004);
        rd(6'h0C, v); chk("R2 cal readback", v, 32'h0000_0004);
        rd(6'h14, v); chk("R2 tick cleared", v, 0);
        step(2);
        rd(6'h14, v); chk("R7 live tick", v, 2);
        step(1);
        rd(6'h10, v); chk("R3 before boundary", v, 0);
        step(1);
        rd(6'h10, v); chk("R3 first second", v, 1);
        rd(6'h20, v); chk("R8 sets while masked", v, 1);
        chk("R9 masked irq low", {31'd0, irq_sec}, 0);

        // set-time
        wr(6'h00, 32'h100);
        rd(6'h04, v); chk("R5 set readback", v, 32'h100);
        rd(6'h10, v); chk("R5 not yet live", v, 1);
        step(2);
        rd(6'h10, v); chk("R5 still old", v, 1);
        step(1);
        rd(6'h10, v); chk("R5 loaded", v, 32'h100);
        step(4);
        rd(6'h10, v); chk("R3 increments", v, 32'h101);

        // set-time on a boundary edge
        step(3);
        wr(6'h00, 32'h200);
        rd(6'h10, v); chk("R5 same-edge increments", v, 32'h102);
        step(4);
        rd(6'h10, v); chk("R5 same-edge loaded later", v, 32'h200);

        // status clear off boundary, then on boundary
        step(1);
        wr(6'h20, 32'h1);
        rd(6'h20, v); chk("R8 W1C clears", v, 0);
        step(1);
        wr(6'h20, 32'h1);
        rd(6'h20, v); chk("R8 set wins over clear", v, 1);
        wr(6'h20, 32'h0);
        rd(6'h20, v); chk("R8 zero write no effect", v, 1);

        wr(6'h28, 32'h1);
        rd(6'h24, v); chk("R9 mask shows enable", v, 1);
        chk("R9 irq_sec high", {31'd0, irq_sec}, 1);
        wr(6'h2C, 32'h1);
        rd(6'h24, v); chk("R9 mask after disable", v, 0);
        chk("R9 irq_sec low", {31'd0, irq_sec}, 0);
        rd(6'h20, v); chk("R8 status kept on disable", v, 1);

        // alarm: cur is 0x201 here, next boundaries give 0x202, 0x203
        wr(6'h18, 32'h203);
        rd(6'h18, v); chk("R10 alarm readback", v, 32'h203);
        wr(6'h28, 32'h2);
        rd(6'h20, v); chk("R10 no early alarm", v & 32'h2, 0);
        step(2);
        rd(6'h20, v); chk("R10 no alarm before match", v & 32'h2, 0);
        step(1);
        rd(6'h10, v); chk("R10 seconds at match", v, 32'h203);
        rd(6'h20, v); chk("R10 alarm set", v & 32'h2, 32'h2);
        chk("R9 irq_alarm high", {31'd0, irq_alarm}, 1);
        wr(6'h20, 32'h2);
        rd(6'h20, v); chk("R8 alarm cleared only", v, 1);
        chk("R9 irq_alarm low", {31'd0, irq_alarm}, 0);

        // wrap
        wr(6'h00, 32'hFFFF_FFFF);
        step(2);
        rd(6'h10, v); chk("R6 at max", v, 32'hFFFF_FFFF);
        step(4);
        rd(6'h10, v); chk("R6 wrapped", v, 0);

        // constrained random calibration with trim
        for (int it = 0; it < 8; it++) begin
            int unsigned t, n;
            bit en;
            t  = 2 + ($urandom % 6);
            n  = $urandom % 16;
            en = (it == 0) ? 1'b1 : 1'($urandom % 2);
            if (it == 0) n = 15;
            if (it == 1) n = 0;
            wr(6'h08, {11'd0, en, 4'(n), 16'(t)});
            rd(6'h0C, v); chk("R2 random cal readback", v, {11'd0, en, 4'(n), 16'(t)});
            for (int s = 0; s < 18; s++) begin
                int unsigned cnt;
                rd(6'h10, prev);
                cnt = 0;
                do begin
                    step(1);
                    cnt++;
                    rd(6'h10, v);
                end while (v == prev && cnt < 40);
                chk(en ? "R4 trimmed period" : "R3 plain period",
                    cnt, exp_period(t, n, en, s));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule